// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block holds the coherence state and tag of every line of one private, direct-mapped cache that sits on a shared bus beside other caches and main memory. It serves one processor request at a time. Hits that need no bus traffic finish locally. Misses, ownership upgrades and evictions of dirty lines become bus requests, and each waits for a grant from an external arbiter. In parallel, it watches every transaction that other agents put on the bus. It answers a snooped transaction with a registered response one cycle later, and it moves the addressed line to its new state.

A line is in one of four states: Invalid, Shared, Exclusive or Modified. Only a Modified line makes memory stale. A read fill lands in Exclusive or Shared, depending on whether another cache reported holding the line. When another agent reads a line held here, this cache reports it as shared. A Modified line is also written back before the line drops to Shared. The `wr_alloc_en` input selects how write misses are handled: either the line is fetched with ownership, or the write goes straight to memory without allocating.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is 1, and `cpu_done`, `bus_req_valid`, `snp_shared` and `snp_supply` are 0. A first access to any address misses.
- R2: A read miss whose bus response has `bus_rsp_shared`=0 fills the line as Exclusive. `cpu_done` pulses with `cpu_hit`=0 in the cycle after the response cycle.
- R3: A read miss whose bus response has `bus_rsp_shared`=1 fills the line as Shared, so a later write to it must request ownership.
- R4: A snooped read (op 01) of a line held clean raises `snp_shared` with `snp_supply`=0 in the next cycle, and the line becomes Shared.
- R5: A processor write that hits a Shared line issues op 10 for its address, and the line becomes Modified.
- R6: A write hit on an Exclusive or Modified line completes with `cpu_hit`=1 and no bus request, and leaves the line Modified. A read hit completes the same way and changes nothing.
- R7: A snooped read of a Modified line raises both `snp_shared` and `snp_supply` in the next cycle, and the line becomes Shared.
- R8: A snooped op 10 or op 11 that matches a held line invalidates it. `snp_supply` is raised only if the line was Modified, and `snp_shared` stays 0.
- R9: With `wr_alloc_en`=1, a write miss issues op 10 for its address, and the line becomes Modified.
- R10: With `wr_alloc_en`=0, a write miss issues op 11 for its own address and leaves the line that occupied the set unchanged.
- R11: A miss whose set holds a Modified line of another address first issues op 11 for the victim address {victim tag, index}, then issues the fill. A clean victim is replaced with no write-back.
- R12: If a snoop takes a pending victim out of Modified before the write-back is granted, the write-back request is withdrawn and the fill is requested instead.
- R13: Bus ops are encoded in 2 bits: 00 idle, 01 read, 10 read-for-ownership/invalidate, 11 write-back or memory write. Op and address are held stable while `bus_req_valid` waits for `bus_grant`. `bus_rsp_shared` is sampled in the cycle after the grant.
- R14: A snoop with op 00, or one whose address does not match a held line, gives no response and changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_alloc_en | input | 1 | 1: write misses allocate; 0: write misses go to memory |
| cpu_valid | input | 1 | Processor request valid (taken when `cpu_ready`) |
| cpu_write | input | 1 | 1 write, 0 read |
| cpu_addr | input | LINE_ADDR_W | Line address {tag, index} |
| cpu_ready | output | 1 | Controller idle, can take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | With `cpu_done`: completed without a bus transaction |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_op | output | 2 | Requested bus op (R13 encoding) |
| bus_req_addr | output | LINE_ADDR_W | Requested line address |
| bus_grant | input | 1 | Arbiter grants the pending request this cycle |
| bus_rsp_shared | input | 1 | Another cache holds the line; valid the cycle after grant |
| snp_valid | input | 1 | Another agent's bus transaction is present |
| snp_op | input | 2 | Snooped op (R13 encoding) |
| snp_addr | input | LINE_ADDR_W | Snooped line address |
| snp_shared | output | 1 | Registered: this cache holds the read line |
| snp_supply | output | 1 | Registered: this cache writes back its Modified copy |

## Verification
The bench steers one set through a full life cycle: Invalid, Exclusive after an unshared fill, Shared after a snooped read, Modified after an upgrade, Shared again after a snooped dirty read, and then evicted. This separates the two fill outcomes and the silent write from the upgrade write. Write misses are run with allocation both on and off, so the case that fetches with ownership is told apart from a plain memory write that leaves the set as it was. Evictions are run with dirty and clean victims to confirm that only dirty ones cost a write-back. A snoop that lands while a write-back waits for a slow grant shows that the stale request is withdrawn. Idle and mismatched snoops show that they change nothing.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_state_t;

  // Bus op encoding is visible at the ports (R13)
  typedef enum logic [1:0] {
    BOP_IDLE = 2'b00,
    BOP_READ = 2'b01,
    BOP_RFO  = 2'b10,
    BOP_WB   = 2'b11
  } bus_op_t;

  typedef enum logic [1:0] {
    CF_IDLE,
    CF_LOOK,
    CF_BUS,
    CF_RSP
  } ctl_state_t;

  typedef enum logic [1:0] {
    PK_READ,
    PK_RFO,
    PK_WRITE,
    PK_EVICT
  } pend_kind_t;

  // State of a held line after another agent's transaction hits it
  function automatic line_state_t snoop_next(line_state_t cur, bus_op_t op);
    case (op)
      BOP_READ:        return LS_SHR;
      BOP_RFO, BOP_WB: return LS_INV;
      default:         return cur;
    endcase
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
`timescale 1ns/1ps
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  // processor-side view and write port
  input  logic [SET_W-1:0]  pa_idx,
  output logic [TAG_W-1:0]  pa_tag,
  output line_state_t       pa_st,
  input  logic              pa_we,
  input  logic [TAG_W-1:0]  pa_wtag,
  input  line_state_t       pa_wst,
  // snoop-side view (includes this cycle's processor write) and state write
  input  logic [SET_W-1:0]  sb_idx,
  output logic [TAG_W-1:0]  sb_tag,
  output line_state_t       sb_st,
  input  logic              sb_we,
  input  line_state_t       sb_wst
);

  localparam int NSETS = 1 << SET_W;

  logic [TAG_W-1:0] tag_mem [NSETS];
  line_state_t      st_mem  [NSETS];

  // Tags carry no reset so they may map to plain RAM; state is cleared.
  always_ff @(posedge clk) begin
    if (pa_we) tag_mem[pa_idx] <= pa_wtag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSETS; i++) st_mem[i] <= LS_INV;
    end else begin
      if (pa_we) st_mem[pa_idx] <= pa_wst;
      // snoop write already folds in a same-set processor write, so it wins
      if (sb_we) st_mem[sb_idx] <= sb_wst;
    end
  end

  assign pa_tag = tag_mem[pa_idx];
  assign pa_st  = st_mem[pa_idx];

  logic bypass;
  assign bypass = pa_we && (pa_idx == sb_idx);
  assign sb_tag = bypass ? pa_wtag : tag_mem[sb_idx];
  assign sb_st  = bypass ? pa_wst  : st_mem[sb_idx];

  // R1: the set addressed right after reset reads back Invalid
  p_reset_inv_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pa_st == LS_INV && sb_st == LS_INV));

endmodule

// File: rtl/mesi_snoop_port.sv
`timescale 1ns/1ps
module mesi_snoop_port
  import mesi_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   snp_valid,
  input  logic [1:0]             snp_op,
  input  logic [TAG_W+SET_W-1:0] snp_addr,
  output logic [SET_W-1:0]       sb_idx,
  input  logic [TAG_W-1:0]       sb_tag,
  input  line_state_t            sb_st,
  output logic                   sb_we,
  output line_state_t            sb_wst,
  output logic                   snp_shared,
  output logic                   snp_supply
);

  bus_op_t op;
  logic    held;

  assign op     = bus_op_t'(snp_op);
  assign sb_idx = snp_addr[SET_W-1:0];
  assign held   = snp_valid && (op != BOP_IDLE) && (sb_st != LS_INV) &&
                  (sb_tag == snp_addr[TAG_W+SET_W-1:SET_W]);

  assign sb_we  = held;
  assign sb_wst = snoop_next(sb_st, op);

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_shared <= 1'b0;
      snp_supply <= 1'b0;
    end else begin
      snp_shared <= held && (op == BOP_READ);
      snp_supply <= held && (sb_st == LS_MOD);
    end
  end

  // R4: a shared answer only ever follows a snooped read
  p_shared_after_read_r4: assert property (@(posedge clk) disable iff (rst)
    snp_shared |-> $past(snp_valid && snp_op == BOP_READ));

  // R7: data is supplied only for a line that was dirty when snooped
  p_supply_dirty_r7: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> $past(sb_st == LS_MOD && snp_valid));

endmodule

// File: rtl/mesi_cpu_fsm.sv
`timescale 1ns/1ps
module mesi_cpu_fsm
  import mesi_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_alloc_en,
  input  logic                   cpu_valid,
  input  logic                   cpu_write,
  input  logic [TAG_W+SET_W-1:0] cpu_addr,
  output logic                   cpu_ready,
  output logic                   cpu_done,
  output logic                   cpu_hit,
  output logic                   bus_req_valid,
  output logic [1:0]             bus_req_op,
  output logic [TAG_W+SET_W-1:0] bus_req_addr,
  input  logic                   bus_grant,
  input  logic                   bus_rsp_shared,
  output logic [SET_W-1:0]       pa_idx,
  input  logic [TAG_W-1:0]       pa_tag,
  input  line_state_t            pa_st,
  output logic                   pa_we,
  output logic [TAG_W-1:0]       pa_wtag,
  output line_state_t            pa_wst
);

  localparam int AW = TAG_W + SET_W;

  ctl_state_t       st, st_n;
  pend_kind_t       kind, kind_n;
  bus_op_t          op_r, op_n;
  logic [AW-1:0]    addr_r, addr_n;
  logic [AW-1:0]    q_addr;
  logic             q_wr;
  logic             done_n, hit_n;

  logic [TAG_W-1:0] q_tag;
  logic             hit, bus_ok;

  assign pa_idx = q_addr[SET_W-1:0];
  assign q_tag  = q_addr[AW-1:SET_W];
  assign hit    = (pa_st != LS_INV) && (pa_tag == q_tag);

  // a pending write-back is only worth doing while the victim is still dirty
  assign bus_ok = (kind != PK_EVICT) ||
                  (pa_st == LS_MOD && pa_tag == addr_r[AW-1:SET_W]);

  assign cpu_ready     = (st == CF_IDLE);
  assign bus_req_valid = (st == CF_BUS) && bus_ok;
  assign bus_req_op    = op_r;
  assign bus_req_addr  = addr_r;

  always_comb begin
    st_n    = st;
    kind_n  = kind;
    op_n    = op_r;
    addr_n  = addr_r;
    done_n  = 1'b0;
    hit_n   = 1'b0;
    pa_we   = 1'b0;
    pa_wtag = q_tag;
    pa_wst  = pa_st;
    case (st)
      CF_IDLE: begin
        if (cpu_valid) st_n = CF_LOOK;
      end
      CF_LOOK: begin
        if (hit && (!q_wr || pa_st != LS_SHR)) begin
          done_n = 1'b1;
          hit_n  = 1'b1;
          st_n   = CF_IDLE;
          if (q_wr && pa_st == LS_EXC) begin
            pa_we  = 1'b1;
            pa_wst = LS_MOD;
          end
        end else begin
          st_n   = CF_BUS;
          addr_n = q_addr;
          if (hit) begin
            kind_n = PK_RFO;
            op_n   = BOP_RFO;
          end else if (q_wr && !wr_alloc_en) begin
            kind_n = PK_WRITE;
            op_n   = BOP_WB;
          end else if (pa_st == LS_MOD) begin
            kind_n = PK_EVICT;
            op_n   = BOP_WB;
            addr_n = {pa_tag, pa_idx};
          end else if (q_wr) begin
            kind_n = PK_RFO;
            op_n   = BOP_RFO;
          end else begin
            kind_n = PK_READ;
            op_n   = BOP_READ;
          end
        end
      end
      CF_BUS: begin
        if (!bus_ok)        st_n = CF_LOOK;
        else if (bus_grant) st_n = CF_RSP;
      end
      CF_RSP: begin
        case (kind)
          PK_EVICT: begin
            pa_we  = 1'b1;
            pa_wst = LS_INV;
            st_n   = CF_LOOK;
          end
          PK_READ: begin
            pa_we  = 1'b1;
            pa_wst = bus_rsp_shared ? LS_SHR : LS_EXC;
            done_n = 1'b1;
            st_n   = CF_IDLE;
          end
          PK_RFO: begin
            pa_we  = 1'b1;
            pa_wst = LS_MOD;
            done_n = 1'b1;
            st_n   = CF_IDLE;
          end
          default: begin
            done_n = 1'b1;
            st_n   = CF_IDLE;
          end
        endcase
      end
      default: st_n = CF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CF_IDLE;
      kind     <= PK_READ;
      op_r     <= BOP_IDLE;
      addr_r   <= '0;
      q_addr   <= '0;
      q_wr     <= 1'b0;
      cpu_done <= 1'b0;
      cpu_hit  <= 1'b0;
    end else begin
      st       <= st_n;
      kind     <= kind_n;
      op_r     <= op_n;
      addr_r   <= addr_n;
      cpu_done <= done_n;
      cpu_hit  <= hit_n;
      if (st == CF_IDLE && cpu_valid) begin
        q_addr <= cpu_addr;
        q_wr   <= cpu_write;
      end
    end
  end

  // R13: an ungranted request keeps its op and address
  p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !bus_grant) |=>
      (!bus_req_valid || ($stable(bus_req_op) && $stable(bus_req_addr))));

  // R13: completion is only reported with the controller idle again
  p_done_ready_r13: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> cpu_ready);

  // R2: a fill response cycle is followed by a miss completion
  p_fill_done_r2: assert property (@(posedge clk) disable iff (rst)
    (st == CF_RSP && kind == PK_READ) |=> (cpu_done && !cpu_hit));

  // R6: hits complete straight from lookup, never after a grant
  p_silent_hit_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_done && cpu_hit) |-> $past(st == CF_LOOK));

  // R11: a pending eviction is presented as a write-back
  p_evict_op_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && kind == PK_EVICT) |-> (bus_req_op == BOP_WB));

endmodule

// File: rtl/mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int LINE_ADDR_W = 12,
  parameter int SET_W       = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_alloc_en,
  input  logic                   cpu_valid,
  input  logic                   cpu_write,
  input  logic [LINE_ADDR_W-1:0] cpu_addr,
  output logic                   cpu_ready,
  output logic                   cpu_done,
  output logic                   cpu_hit,
  output logic                   bus_req_valid,
  output logic [1:0]             bus_req_op,
  output logic [LINE_ADDR_W-1:0] bus_req_addr,
  input  logic                   bus_grant,
  input  logic                   bus_rsp_shared,
  input  logic                   snp_valid,
  input  logic [1:0]             snp_op,
  input  logic [LINE_ADDR_W-1:0] snp_addr,
  output logic                   snp_shared,
  output logic                   snp_supply
);

  localparam int TAG_W = LINE_ADDR_W - SET_W;

  logic [SET_W-1:0] pa_idx, sb_idx;
  logic [TAG_W-1:0] pa_tag, sb_tag, pa_wtag;
  line_state_t      pa_st, sb_st, pa_wst, sb_wst;
  logic             pa_we, sb_we;

  mesi_line_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .pa_idx  (pa_idx),
    .pa_tag  (pa_tag),
    .pa_st   (pa_st),
    .pa_we   (pa_we),
    .pa_wtag (pa_wtag),
    .pa_wst  (pa_wst),
    .sb_idx  (sb_idx),
    .sb_tag  (sb_tag),
    .sb_st   (sb_st),
    .sb_we   (sb_we),
    .sb_wst  (sb_wst)
  );

  mesi_snoop_port #(.SET_W(SET_W), .TAG_W(TAG_W)) u_snoop (
    .clk        (clk),
    .rst        (rst),
    .snp_valid  (snp_valid),
    .snp_op     (snp_op),
    .snp_addr   (snp_addr),
    .sb_idx     (sb_idx),
    .sb_tag     (sb_tag),
    .sb_st      (sb_st),
    .sb_we      (sb_we),
    .sb_wst     (sb_wst),
    .snp_shared (snp_shared),
    .snp_supply (snp_supply)
  );

  mesi_cpu_fsm #(.SET_W(SET_W), .TAG_W(TAG_W)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .wr_alloc_en    (wr_alloc_en),
    .cpu_valid      (cpu_valid),
    .cpu_write      (cpu_write),
    .cpu_addr       (cpu_addr),
    .cpu_ready      (cpu_ready),
    .cpu_done       (cpu_done),
    .cpu_hit        (cpu_hit),
    .bus_req_valid  (bus_req_valid),
    .bus_req_op     (bus_req_op),
    .bus_req_addr   (bus_req_addr),
    .bus_grant      (bus_grant),
    .bus_rsp_shared (bus_rsp_shared),
    .pa_idx         (pa_idx),
    .pa_tag         (pa_tag),
    .pa_st          (pa_st),
    .pa_we          (pa_we),
    .pa_wtag        (pa_wtag),
    .pa_wst         (pa_wst)
  );

endmodule

// File: tb/mesi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_test;

  localparam int AW = 12;
  localparam int SW = 4;
  localparam int NS = 1 << SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_alloc_en = 1'b1;
  logic          cpu_valid = 1'b0;
  logic          cpu_write = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_ready, cpu_done, cpu_hit;
  logic          bus_req_valid;
  logic [1:0]    bus_req_op;
  logic [AW-1:0] bus_req_addr;
  logic          bus_grant = 1'b0;
  logic          bus_rsp_shared = 1'b0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_op = 2'b00;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_shared, snp_supply;

  mesi_snoop_ctrl #(.LINE_ADDR_W(AW), .SET_W(SW)) uut (.*);

  always #4 clk = ~clk;   // 125 MHz

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string cur = "R1";

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // line states: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified
  logic [AW-SW-1:0] m_tag [NS];
  int               m_st  [NS];
  int               ph;        // 0 idle, 1 lookup, 2 waiting for bus, 3 response
  logic [AW-1:0]    q_a;
  bit               q_w;
  int               kind;      // 0 read, 1 ownership, 2 memory write, 3 evict
  logic [AW-1:0]    p_addr;
  int               p_op;
  bit               e_done, e_hit, e_sh, e_sup;

  function automatic bit m_bus_ok();
    int ix;
    if (ph != 2) return 1'b0;
    if (kind != 3) return 1'b1;
    ix = int'(q_a[SW-1:0]);
    return (m_st[ix] == 3) && (m_tag[ix] == p_addr[AW-1:SW]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) m_st[i] = 0;
      ph = 0; kind = 0; p_op = 0; p_addr = '0; q_a = '0; q_w = 0;
      e_done = 0; e_hit = 0; e_sh = 0; e_sup = 0;
    end else begin
      int  ix;
      bit  h;
      ix = int'(q_a[SW-1:0]);
      h  = (m_st[ix] != 0) && (m_tag[ix] == q_a[AW-1:SW]);
      e_done = 0; e_hit = 0;
      case (ph)
        0: if (cpu_valid) begin q_a = cpu_addr; q_w = cpu_write; ph = 1; end
        1: begin
          if (h && (!q_w || m_st[ix] >= 2)) begin
            e_done = 1; e_hit = 1; ph = 0;
            if (q_w) m_st[ix] = 3;
          end else begin
            ph = 2; p_addr = q_a;
            if (h) begin kind = 1; p_op = 2; end
            else if (q_w && !wr_alloc_en) begin kind = 2; p_op = 3; end
            else if (m_st[ix] == 3) begin kind = 3; p_op = 3; p_addr = {m_tag[ix], q_a[SW-1:0]}; end
            else if (q_w) begin kind = 1; p_op = 2; end
            else begin kind = 0; p_op = 1; end
          end
        end
        2: begin
          if (!m_bus_ok()) ph = 1;
          else if (bus_grant) ph = 3;
        end
        default: begin
          if (kind == 3) begin m_st[ix] = 0; ph = 1; end
          else begin
            if (kind == 0) begin m_tag[ix] = q_a[AW-1:SW]; m_st[ix] = bus_rsp_shared ? 1 : 2; end
            if (kind == 1) begin m_tag[ix] = q_a[AW-1:SW]; m_st[ix] = 3; end
            e_done = 1; ph = 0;
          end
        end
      endcase
      e_sh = 0; e_sup = 0;
      if (snp_valid && snp_op != 2'b00) begin
        int sx;
        sx = int'(snp_addr[SW-1:0]);
        if (m_st[sx] != 0 && m_tag[sx] == snp_addr[AW-1:SW]) begin
          e_sh  = (snp_op == 2'b01);
          e_sup = (m_st[sx] == 3);
          m_st[sx] = (snp_op == 2'b01) ? 1 : 0;
        end
      end
    end
  end

  // ---------------- arbiter, response and per-cycle compare ----------------
  int              gdelay  = 0;
  int              gcnt    = 0;
  bit              rsp_val = 0;
  logic [AW+1:0]   granted[$];

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      bit bv;
      bv = m_bus_ok();
      check(cpu_ready == (ph == 0), cur, "cpu_ready", cpu_ready, ph == 0);
      check(cpu_done == e_done, cur, "cpu_done", cpu_done, e_done);
      if (e_done) check(cpu_hit == e_hit, cur, "cpu_hit", cpu_hit, e_hit);
      check(bus_req_valid == bv, cur, "bus_req_valid", bus_req_valid, bv);
      if (bv) begin
        check(bus_req_op == p_op[1:0], cur, "bus_req_op", bus_req_op, p_op);
        check(bus_req_addr == p_addr, cur, "bus_req_addr", bus_req_addr, p_addr);
      end
      check(snp_shared == e_sh, cur, "snp_shared", snp_shared, e_sh);
      check(snp_supply == e_sup, cur, "snp_supply", snp_supply, e_sup);
    end
    bus_rsp_shared = bus_grant ? rsp_val : 1'b0;
    if (bus_req_valid && gcnt >= gdelay) begin
      bus_grant = 1'b1;
      granted.push_back({bus_req_op, bus_req_addr});
      gcnt = 0;
    end else begin
      bus_grant = 1'b0;
      gcnt = bus_req_valid ? gcnt + 1 : 0;
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog %s actual %0d expected %0d", cur, cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  bit last_hit;
  bit s_sh, s_sup;

  task automatic cpu_op(bit w, logic [AW-1:0] a, bit sh);
    rsp_val = sh;
    @(negedge clk); #1;
    cpu_valid = 1'b1; cpu_write = w; cpu_addr = a;
    @(negedge clk); #1;
    cpu_valid = 1'b0;
    do @(negedge clk); while (!cpu_done);
    last_hit = cpu_hit;
  endtask

  task automatic snoop(logic [1:0] op, logic [AW-1:0] a);
    @(negedge clk); #1;
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    @(negedge clk);
    s_sh = snp_shared; s_sup = snp_supply;
    #1 snp_valid = 1'b0; snp_op = 2'b00;
  endtask

  task automatic expect_grant(string tag, logic [1:0] op, logic [AW-1:0] a);
    logic [AW+1:0] g;
    if (granted.size() == 0) begin
      check(1'b0, tag, "granted op/addr (none)", 0, {op, a});
    end else begin
      g = granted.pop_front();
      check(g == {op, a}, tag, "granted op/addr", g, {op, a});
    end
  endtask

  task automatic expect_quiet(string tag);
    check(granted.size() == 0, tag, "bus transactions", granted.size(), 0);
    granted.delete();
  endtask

  localparam logic [AW-1:0] LA  = 12'h013, LB  = 12'h023;
  localparam logic [AW-1:0] LC  = 12'h045, LC2 = 12'h0A5;
  localparam logic [AW-1:0] LE1 = 12'h067, LE2 = 12'h0B7;
  localparam logic [AW-1:0] LF  = 12'h089, LF2 = 12'h0C9, LG = 12'h02B;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    cur = "R1";
    check(cpu_ready && !cpu_done && !bus_req_valid && !snp_shared && !snp_supply,
          "R1", "reset outputs", {cpu_ready, cpu_done, bus_req_valid, snp_shared, snp_supply}, 5'b10000);
    // R14: snoop read on an empty cache gets no answer
    cur = "R14";
    snoop(2'b01, LA);
    check(!s_sh && !s_sup, "R14", "empty snoop response", {s_sh, s_sup}, 0);

    // R2: unshared read fill
    cur = "R2";
    cpu_op(0, LA, 0);
    check(!last_hit, "R2", "miss hit flag", last_hit, 0);
    expect_grant("R2", 2'b01, LA);

    // R4: snooped read of clean line
    cur = "R4";
    snoop(2'b01, LA);
    check(s_sh && !s_sup, "R4", "clean snoop response", {s_sh, s_sup}, 2'b10);

    // R5: write hit on Shared upgrades
    cur = "R5";
    cpu_op(1, LA, 0);
    expect_grant("R5", 2'b10, LA);

    // R6: write and read hits on Modified are silent
    cur = "R6";
    cpu_op(1, LA, 0);
    check(last_hit, "R6", "write hit flag", last_hit, 1);
    cpu_op(0, LA, 0);
    check(last_hit, "R6", "read hit flag", last_hit, 1);
    expect_quiet("R6");

    // R7: snooped read of dirty line supplies and shares
    cur = "R7";
    snoop(2'b01, LA);
    check(s_sh && s_sup, "R7", "dirty snoop response", {s_sh, s_sup}, 2'b11);
    cpu_op(1, LA, 0);
    expect_grant("R7", 2'b10, LA);

    // R11: dirty victim written back before fill; R3: shared fill
    cur = "R11";
    cpu_op(0, LB, 1);
    expect_grant("R11", 2'b11, LA);
    expect_grant("R11", 2'b01, LB);
    cur = "R3";
    cpu_op(1, LB, 0);
    expect_grant("R3", 2'b10, LB);

    // R8: ownership and write snoops invalidate
    cur = "R8";
    snoop(2'b10, LB);
    check(!s_sh && s_sup, "R8", "ownership snoop on dirty", {s_sh, s_sup}, 2'b01);
    cpu_op(0, LB, 0);
    expect_grant("R8", 2'b01, LB);
    snoop(2'b11, LB);
    check(!s_sh && !s_sup, "R8", "write snoop on clean", {s_sh, s_sup}, 0);
    cpu_op(0, LB, 0);
    expect_grant("R8", 2'b01, LB);

    // R9: allocating write miss
    cur = "R9";
    wr_alloc_en = 1'b1;
    cpu_op(1, LC, 0);
    expect_grant("R9", 2'b10, LC);
    cpu_op(1, LC, 0);
    check(last_hit, "R9", "line now Modified", last_hit, 1);
    expect_quiet("R9");

    // R12: victim cleaned by a snoop while its write-back waits
    cur = "R12";
    gdelay = 4; rsp_val = 0;
    @(negedge clk); #1;
    cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = LC2;
    @(negedge clk); #1;
    cpu_valid = 1'b0;
    while (!bus_req_valid) @(negedge clk);
    #1 snp_valid = 1'b1; snp_op = 2'b01; snp_addr = LC;
    @(negedge clk);
    s_sh = snp_shared; s_sup = snp_supply;
    #1 snp_valid = 1'b0; snp_op = 2'b00;
    check(s_sh && s_sup, "R12", "victim snoop response", {s_sh, s_sup}, 2'b11);
    do @(negedge clk); while (!cpu_done);
    expect_grant("R12", 2'b01, LC2);
    expect_quiet("R12");
    gdelay = 0;

    // R10: non-allocating write miss leaves the set alone
    cur = "R10";
    cpu_op(0, LF, 0);
    expect_grant("R10", 2'b01, LF);
    wr_alloc_en = 1'b0;
    cpu_op(1, LF2, 0);
    expect_grant("R10", 2'b11, LF2);
    cpu_op(0, LF, 0);
    check(last_hit, "R10", "old line still held", last_hit, 1);
    cpu_op(0, LF2, 0);
    expect_grant("R10", 2'b01, LF2);
    wr_alloc_en = 1'b1;

    // R11: clean victim replaced without write-back
    cur = "R11";
    cpu_op(0, LE1, 0);
    expect_grant("R11", 2'b01, LE1);
    cpu_op(0, LE2, 0);
    expect_grant("R11", 2'b01, LE2);
    expect_quiet("R11");

    // R14: idle-op and mismatched snoops change nothing
    cur = "R14";
    snoop(2'b00, LE2);
    check(!s_sh && !s_sup, "R14", "idle-op snoop", {s_sh, s_sup}, 0);
    snoop(2'b10, LE1);
    check(!s_sh && !s_sup, "R14", "tag-mismatch snoop", {s_sh, s_sup}, 0);
    cpu_op(1, LE2, 0);
    check(last_hit, "R14", "line still Exclusive", last_hit, 1);
    expect_quiet("R14");

    // R13: slow grant, request held, response sampled after grant
    cur = "R13";
    gdelay = 3;
    cpu_op(0, LG, 1);
    expect_grant("R13", 2'b01, LG);
    gdelay = 0;
    cpu_op(1, LG, 0);
    expect_grant("R13", 2'b10, LG);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule